// File: doc/BRIEF.md
# Directional Rectangle Copy Engine

This block moves a rectangle of pixels from one place to another inside a single byte-addressed frame-buffer memory. A start pulse launches it with a set of held configuration inputs: source and destination coordinates, width, height, a pixel format code, two direction flags, and either per-side or shared pitch and base values. The engine checks the parameters, resolves the true start corners, copies the rectangle one byte at a time through a synchronous memory port, and then presents the updated destination coordinates.

When a direction flag selects the reverse order, the given coordinate is the far edge of the rectangle. Rows are then visited in the matching vertical order, and the bytes within a row are visited in the order that the two row addresses allow. This lets a region slide onto itself without corrupting the data. A rejected operation touches no memory and pulses an error output in place of done.

The control is one state machine with these states: IDLE (waits for start), CHECK (validates the latched setup), ROW (computes the row addresses and the byte order), READ (issues a memory read), WRITE (writes the byte just read), DONE (pulses done) and FAIL (pulses error). The transitions are: IDLE to CHECK on start. CHECK goes to FAIL when the setup is rejected, to DONE when the rectangle is empty, and to ROW otherwise. ROW goes to READ. READ goes to WRITE. WRITE goes to READ within a row, to ROW at the end of a row, and to DONE after the last row. DONE and FAIL both return to IDLE.

Top module: `rect_mover`

## Requirements
- R1: The low four bits of `pix_fmt` give the bytes per pixel: code 2 is 1 byte, codes 3 and 4 are 2 bytes, code 5 is 3 bytes, code 6 is 4 bytes. Any other code rejects the operation.
- R2: With `x_fwd`=1 the destination left edge is `dst_x`. With `x_fwd`=0 it is `dst_x`+1−`width`, computed modulo 2^16. The top edge follows the same rule using `y_fwd`, `dst_y` and `height`.
- R3: The source left and top edges follow the rule of R2 using `src_x`/`src_y` and the same `width`/`height`.
- R4: A resolved source or destination left or top edge above 0x3FFF rejects the operation, and a rejected operation performs no memory write.
- R5: A selected source or destination pitch of zero rejects the operation.
- R6: With `use_own`=1 the source uses `src_pitch`/`src_base` and the destination uses `dst_pitch`/`dst_base`. With `use_own`=0 both sides use `shared_pitch`/`shared_base`.
- R7: With `y_fwd`=1 the rows are copied from row 0 downward. With `y_fwd`=0 they are copied from the last row upward.
- R8: The address of row r on a side is base + (top + r)·pitch + left·bpp. Each row moves `width`·bpp bytes. Within a row, bytes go in ascending order when the destination row address is below the source row address, and in descending order otherwise. An overlapping move in the safe direction leaves the destination equal to the original source.
- R9: For a non-empty rectangle, if base + (top + height − 1)·pitch + (left + width)·bpp exceeds the memory size on either side, the operation is rejected. An end value exactly equal to the memory size is accepted.
- R10: When done pulses, `next_dst_x` is left+`width` if `x_fwd`=1 and left otherwise, and `next_dst_y` is top+`height` if `y_fwd`=1 and top otherwise.
- R11: `start` is taken only while `busy` is low. `busy` stays high until exactly one of `done` or `error` pulses for one cycle, and it drops in the following cycle.
- R12: A valid setup with zero width or zero height makes no memory access and pulses done.
- R13: `mem_rd` and `mem_wr` are never high together. Each write follows a read in the previous cycle and carries the byte that read returned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Launch pulse, taken while idle |
| use_own | input | 1 | 1: per-side pitch and base; 0: shared pitch and base |
| pix_fmt | input | 4 | Pixel format code |
| x_fwd | input | 1 | 1: left-to-right, coordinate is the left edge |
| y_fwd | input | 1 | 1: top-to-bottom, coordinate is the top edge |
| src_x | input | CW | Source X coordinate |
| src_y | input | CW | Source Y coordinate |
| dst_x | input | CW | Destination X coordinate |
| dst_y | input | CW | Destination Y coordinate |
| width | input | CW | Rectangle width in pixels |
| height | input | CW | Rectangle height in rows |
| src_pitch | input | CW | Source row pitch in bytes |
| dst_pitch | input | CW | Destination row pitch in bytes |
| shared_pitch | input | CW | Shared row pitch in bytes |
| src_base | input | BW | Source base byte address |
| dst_base | input | BW | Destination base byte address |
| shared_base | input | BW | Shared base byte address |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| error | output | 1 | One-cycle rejection pulse |
| next_dst_x | output | CW | Updated destination X, valid with done |
| next_dst_y | output | CW | Updated destination Y, valid with done |
| mem_addr | output | log2(MEM_BYTES) | Memory byte address |
| mem_rd | output | 1 | Memory read strobe; data arrives next cycle |
| mem_wr | output | 1 | Memory write strobe |
| mem_wdata | output | 8 | Write data |
| mem_rdata | input | 8 | Read data |

## Verification
Two functions can land in the same cycle: the completion pulse and a new `start`, since a caller may request the next copy at the moment the previous one finishes. The bench raises `start` in exactly the cycle where it sees `done`. It then requires `busy` to be low in the next cycle and to stay low, with no memory read, for several cycles after. A reference model in the bench predicts the write stream byte by byte and compares it with every write. After each valid operation, the destination rectangle is also compared with a snapshot of the original source. For overlapping moves this shows that the row order and the byte order work together correctly.

// File: rtl/rm_pkg.sv
package rm_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CHECK,
        ST_ROW,
        ST_READ,
        ST_WRITE,
        ST_DONE,
        ST_FAIL
    } rm_state_e;

    localparam int COORD_LIMIT = 16'h3FFF;

    // Format code to bytes per pixel; zero marks an unsupported code.
    function automatic logic [2:0] bytes_per_pixel(input logic [3:0] code);
        unique case (code)
            4'd2:        return 3'd1;
            4'd3, 4'd4:  return 3'd2;
            4'd5:        return 3'd3;
            4'd6:        return 3'd4;
            default:     return 3'd0;
        endcase
    endfunction

endpackage

// File: rtl/rm_corner.sv
module rm_corner #(
    parameter int CW = 16
) (
    input  logic [CW-1:0] pos,
    input  logic [CW-1:0] span,
    input  logic          reverse,
    output logic [CW-1:0] corner
);
    // A reversed coordinate names the far edge; step back to the near one.
    assign corner = reverse ? (pos + CW'(1) - span) : pos;
endmodule

// File: rtl/rm_limit.sv
module rm_limit #(
    parameter int MEM_BYTES = 4096,
    parameter int CW        = 16,
    parameter int BW        = 24,
    parameter int XW        = 36
) (
    input  logic [2:0]    bpp,
    input  logic [CW-1:0] s_pitch,
    input  logic [CW-1:0] d_pitch,
    input  logic [BW-1:0] s_base,
    input  logic [BW-1:0] d_base,
    input  logic [CW-1:0] s_left,
    input  logic [CW-1:0] s_top,
    input  logic [CW-1:0] d_left,
    input  logic [CW-1:0] d_top,
    input  logic [CW-1:0] w,
    input  logic [CW-1:0] h,
    output logic          reject,
    output logic          empty
);
    import rm_pkg::*;

    function automatic logic [XW-1:0] span_end(
        input logic [BW-1:0] base,
        input logic [CW-1:0] top,
        input logic [CW-1:0] left,
        input logic [CW-1:0] pitch
    );
        return XW'(base)
             + (XW'(top) + XW'(h) - XW'(1)) * XW'(pitch)
             + (XW'(left) + XW'(w)) * XW'(bpp);
    endfunction

    logic bad_fmt, bad_pitch, bad_coord, oob;

    always_comb begin
        bad_fmt   = (bpp == 3'd0);
        bad_pitch = (s_pitch == '0) || (d_pitch == '0);
        bad_coord = (s_left > CW'(COORD_LIMIT)) || (s_top > CW'(COORD_LIMIT))
                 || (d_left > CW'(COORD_LIMIT)) || (d_top > CW'(COORD_LIMIT));
        empty     = (w == '0) || (h == '0);
        oob       = !empty && ((span_end(s_base, s_top, s_left, s_pitch) > XW'(MEM_BYTES))
                            || (span_end(d_base, d_top, d_left, d_pitch) > XW'(MEM_BYTES)));
        reject    = bad_fmt || bad_pitch || bad_coord || oob;
    end
endmodule

// File: rtl/rect_mover.sv
module rect_mover
    import rm_pkg::*;
#(
    parameter int MEM_BYTES = 4096,
    parameter int CW        = 16,
    parameter int BW        = 24
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         start,
    input  logic                         use_own,
    input  logic [3:0]                   pix_fmt,
    input  logic                         x_fwd,
    input  logic                         y_fwd,
    input  logic [CW-1:0]                src_x,
    input  logic [CW-1:0]                src_y,
    input  logic [CW-1:0]                dst_x,
    input  logic [CW-1:0]                dst_y,
    input  logic [CW-1:0]                width,
    input  logic [CW-1:0]                height,
    input  logic [CW-1:0]                src_pitch,
    input  logic [CW-1:0]                dst_pitch,
    input  logic [CW-1:0]                shared_pitch,
    input  logic [BW-1:0]                src_base,
    input  logic [BW-1:0]                dst_base,
    input  logic [BW-1:0]                shared_base,
    output logic                         busy,
    output logic                         done,
    output logic                         error,
    output logic [CW-1:0]                next_dst_x,
    output logic [CW-1:0]                next_dst_y,
    output logic [$clog2(MEM_BYTES)-1:0] mem_addr,
    output logic                         mem_rd,
    output logic                         mem_wr,
    output logic [7:0]                   mem_wdata,
    input  logic [7:0]                   mem_rdata
);
    localparam int AW = $clog2(MEM_BYTES);
    localparam int XW = ((BW > 2*CW) ? BW : 2*CW) + 4;
    localparam int LW = CW + 3;
    localparam int NC = 4;   // corners: 0 dst x, 1 dst y, 2 src x, 3 src y

    rm_state_e state, state_n;

    logic [CW-1:0] sx_r, sy_r, dx_r, dy_r, w_r, h_r, sp_r, dp_r;
    logic [BW-1:0] sb_r, db_r;
    logic [2:0]    bpp_r;
    logic          xf_r, yf_r;
    logic [CW-1:0] row_cnt;
    logic [LW-1:0] byte_cnt, row_len;
    logic [XW-1:0] src_row, dst_row;
    logic          asc;

    // ---------------- corner resolution ----------------
    logic [CW-1:0] pos  [NC];
    logic [CW-1:0] crn  [NC];
    assign pos[0] = dx_r;
    assign pos[1] = dy_r;
    assign pos[2] = sx_r;
    assign pos[3] = sy_r;

    for (genvar g = 0; g < NC; g++) begin : g_corner
        rm_corner #(.CW(CW)) u_corner (
            .pos     (pos[g]),
            .span    ((g % 2 == 0) ? w_r : h_r),
            .reverse ((g % 2 == 0) ? !xf_r : !yf_r),
            .corner  (crn[g])
        );
    end

    // ---------------- parameter validation ----------------
    logic reject, empty;
    rm_limit #(.MEM_BYTES(MEM_BYTES), .CW(CW), .BW(BW), .XW(XW)) u_limit (
        .bpp     (bpp_r),
        .s_pitch (sp_r),
        .d_pitch (dp_r),
        .s_base  (sb_r),
        .d_base  (db_r),
        .s_left  (crn[2]),
        .s_top   (crn[3]),
        .d_left  (crn[0]),
        .d_top   (crn[1]),
        .w       (w_r),
        .h       (h_r),
        .reject  (reject),
        .empty   (empty)
    );

    // ---------------- row address computation ----------------
    logic [CW-1:0] y_idx;
    logic [XW-1:0] src_row_n, dst_row_n;
    logic [LW-1:0] offset;
    logic          last_byte, last_row;

    always_comb begin
        y_idx     = yf_r ? row_cnt : (h_r - CW'(1) - row_cnt);
        src_row_n = XW'(sb_r) + (XW'(crn[3]) + XW'(y_idx)) * XW'(sp_r) + XW'(crn[2]) * XW'(bpp_r);
        dst_row_n = XW'(db_r) + (XW'(crn[1]) + XW'(y_idx)) * XW'(dp_r) + XW'(crn[0]) * XW'(bpp_r);
        offset    = asc ? byte_cnt : (row_len - LW'(1) - byte_cnt);
        last_byte = (byte_cnt == row_len - LW'(1));
        last_row  = (row_cnt == h_r - CW'(1));
    end

    // ---------------- next-state logic ----------------
    always_comb begin
        state_n = state;
        unique case (state)
            ST_IDLE:  if (start) state_n = ST_CHECK;
            ST_CHECK: state_n = reject ? ST_FAIL : (empty ? ST_DONE : ST_ROW);
            ST_ROW:   state_n = ST_READ;
            ST_READ:  state_n = ST_WRITE;
            ST_WRITE: state_n = !last_byte ? ST_READ : (last_row ? ST_DONE : ST_ROW);
            ST_DONE:  state_n = ST_IDLE;
            ST_FAIL:  state_n = ST_IDLE;
        endcase
    end

    // ---------------- state register and datapath ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            sx_r     <= '0; sy_r <= '0; dx_r <= '0; dy_r <= '0;
            w_r      <= '0; h_r  <= '0; sp_r <= '0; dp_r <= '0;
            sb_r     <= '0; db_r <= '0;
            bpp_r    <= '0; xf_r <= 1'b1; yf_r <= 1'b1;
            row_cnt  <= '0; byte_cnt <= '0; row_len <= '0;
            src_row  <= '0; dst_row  <= '0; asc <= 1'b0;
        end else begin
            state <= state_n;
            unique case (state)
                ST_IDLE: if (start) begin
                    sx_r  <= src_x;  sy_r <= src_y;
                    dx_r  <= dst_x;  dy_r <= dst_y;
                    w_r   <= width;  h_r  <= height;
                    sp_r  <= use_own ? src_pitch : shared_pitch;
                    dp_r  <= use_own ? dst_pitch : shared_pitch;
                    sb_r  <= use_own ? src_base  : shared_base;
                    db_r  <= use_own ? dst_base  : shared_base;
                    bpp_r <= bytes_per_pixel(pix_fmt);
                    xf_r  <= x_fwd;  yf_r <= y_fwd;
                end
                ST_CHECK: begin
                    row_cnt <= '0;
                    row_len <= LW'(w_r) * LW'(bpp_r);
                end
                ST_ROW: begin
                    src_row  <= src_row_n;
                    dst_row  <= dst_row_n;
                    asc      <= (dst_row_n < src_row_n);
                    byte_cnt <= '0;
                end
                ST_WRITE: begin
                    if (last_byte) row_cnt  <= row_cnt + CW'(1);
                    else           byte_cnt <= byte_cnt + LW'(1);
                end
                default: ;
            endcase
        end
    end

    // ---------------- outputs ----------------
    always_comb begin
        busy      = (state != ST_IDLE);
        done      = (state == ST_DONE);
        error     = (state == ST_FAIL);
        mem_rd    = (state == ST_READ);
        mem_wr    = (state == ST_WRITE);
        mem_addr  = AW'(((state == ST_READ) ? src_row : dst_row) + XW'(offset));
        mem_wdata = (state == ST_WRITE) ? mem_rdata : 8'h00;
    end

    assign next_dst_x = xf_r ? (crn[0] + w_r) : crn[0];
    assign next_dst_y = yf_r ? (crn[1] + h_r) : crn[1];

    // ---------------- assertions ----------------
    assert_rd_wr_excl_R13: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd && mem_wr));

    assert_wr_after_rd_R13: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr |-> $past(mem_rd));

    assert_done_err_excl_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && error));

    assert_busy_release_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> $past(done || error));

    assert_single_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (done || error) |=> !(done || error));

    assert_no_write_on_reject_R4: assert property (@(posedge clk) disable iff (!rst_n)
        error |-> !$past(mem_wr));
endmodule

// File: tb/rect_mover_bench.sv
module rect_mover_bench;
    localparam int MEM = 4096;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        cfg_own = 1'b1;
    logic [3:0]  cfg_fmt = 4'd2;
    logic        cfg_xf = 1'b1, cfg_yf = 1'b1;
    logic [15:0] cfg_sx = '0, cfg_sy = '0, cfg_dx = '0, cfg_dy = '0;
    logic [15:0] cfg_w = '0, cfg_h = '0;
    logic [15:0] cfg_sp = '0, cfg_dp = '0, cfg_shp = '0;
    logic [23:0] cfg_sb = '0, cfg_db = '0, cfg_shb = '0;

    logic        busy, done, error, mem_rd, mem_wr;
    logic [15:0] next_dst_x, next_dst_y;
    logic [11:0] mem_addr;
    logic [7:0]  mem_wdata;
    logic [7:0]  mem_rdata = 8'h00;

    logic [7:0]  tb_mem  [MEM];
    logic [7:0]  ref_mem [MEM];
    logic [7:0]  snap    [MEM];

    int checks = 0;
    int errors = 0;
    int exp_addr[$];
    int exp_data[$];
    string cur_tag = "R8";

    // model geometry
    int   m_b, m_sp, m_dp, m_sb, m_db;
    logic [15:0] m_sl, m_st, m_dl, m_dt, m_nx, m_ny;
    bit   m_err, m_empty;

    always #10 clk = ~clk;   // 50 MHz

    rect_mover u_rect_mover (
        .clk(clk), .rst_n(rst_n), .start(start), .use_own(cfg_own), .pix_fmt(cfg_fmt),
        .x_fwd(cfg_xf), .y_fwd(cfg_yf), .src_x(cfg_sx), .src_y(cfg_sy),
        .dst_x(cfg_dx), .dst_y(cfg_dy), .width(cfg_w), .height(cfg_h),
        .src_pitch(cfg_sp), .dst_pitch(cfg_dp), .shared_pitch(cfg_shp),
        .src_base(cfg_sb), .dst_base(cfg_db), .shared_base(cfg_shb),
        .busy(busy), .done(done), .error(error),
        .next_dst_x(next_dst_x), .next_dst_y(next_dst_y),
        .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_wr(mem_wr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
    );

    // synchronous byte memory, one-cycle read latency
    always @(posedge clk) begin
        if (mem_wr) tb_mem[mem_addr] <= mem_wdata;
        if (mem_rd) mem_rdata <= tb_mem[mem_addr];
    end

    task automatic chk(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    // per-clock comparison of the write stream against the model (R8, R13)
    always @(negedge clk) begin
        if (rst_n) begin
            if (mem_rd && mem_wr)
                chk(1'b0, "R13", "read and write together", 1, 0);
            if (mem_wr) begin
                if (exp_addr.size() == 0) begin
                    chk(1'b0, cur_tag, "unexpected write addr", longint'(mem_addr), -1);
                end else begin
                    int ea, ed;
                    ea = exp_addr.pop_front();
                    ed = exp_data.pop_front();
                    chk(int'(mem_addr) == ea && int'(mem_wdata) == ed, cur_tag,
                        "write addr*256+data", longint'(mem_addr) * 256 + mem_wdata,
                        longint'(ea) * 256 + ed);
                end
            end
        end
    end

    function automatic int bpp_of(input logic [3:0] c);
        case (c)
            4'd2:       return 1;
            4'd3, 4'd4: return 2;
            4'd5:       return 3;
            4'd6:       return 4;
            default:    return 0;
        endcase
    endfunction

    task automatic build_model();
        longint es, ed;
        m_b  = bpp_of(cfg_fmt);
        m_sp = cfg_own ? int'(cfg_sp) : int'(cfg_shp);
        m_dp = cfg_own ? int'(cfg_dp) : int'(cfg_shp);
        m_sb = cfg_own ? int'(cfg_sb) : int'(cfg_shb);
        m_db = cfg_own ? int'(cfg_db) : int'(cfg_shb);
        m_dl = cfg_xf ? cfg_dx : 16'(cfg_dx + 16'd1 - cfg_w);
        m_dt = cfg_yf ? cfg_dy : 16'(cfg_dy + 16'd1 - cfg_h);
        m_sl = cfg_xf ? cfg_sx : 16'(cfg_sx + 16'd1 - cfg_w);
        m_st = cfg_yf ? cfg_sy : 16'(cfg_sy + 16'd1 - cfg_h);
        m_nx = cfg_xf ? 16'(m_dl + cfg_w) : m_dl;
        m_ny = cfg_yf ? 16'(m_dt + cfg_h) : m_dt;
        m_empty = (cfg_w == 0) || (cfg_h == 0);
        m_err = (m_b == 0) || (m_sp == 0) || (m_dp == 0) ||
                (m_dl > 16'h3FFF) || (m_dt > 16'h3FFF) ||
                (m_sl > 16'h3FFF) || (m_st > 16'h3FFF);
        if (!m_err && !m_empty) begin
            es = longint'(m_sb) + (longint'(m_st) + cfg_h - 1) * m_sp + (longint'(m_sl) + cfg_w) * m_b;
            ed = longint'(m_db) + (longint'(m_dt) + cfg_h - 1) * m_dp + (longint'(m_dl) + cfg_w) * m_b;
            if (es > MEM || ed > MEM) m_err = 1'b1;
        end
        exp_addr.delete();
        exp_data.delete();
        if (!m_err && !m_empty) begin
            for (int r = 0; r < int'(cfg_h); r++) begin
                int y, srow, drow, n;
                bit up;
                y    = cfg_yf ? r : int'(cfg_h) - 1 - r;
                srow = m_sb + (int'(m_st) + y) * m_sp + int'(m_sl) * m_b;
                drow = m_db + (int'(m_dt) + y) * m_dp + int'(m_dl) * m_b;
                n    = int'(cfg_w) * m_b;
                up   = drow < srow;
                for (int k = 0; k < n; k++) begin
                    int off;
                    off = up ? k : n - 1 - k;
                    ref_mem[drow + off] = ref_mem[srow + off];
                    exp_addr.push_back(drow + off);
                    exp_data.push_back(int'(ref_mem[drow + off]));
                end
            end
        end
    endtask

    task automatic run_op(input string tag, input bit chk_move, input bit hold_start);
        int n;
        int bad;
        cur_tag = tag;
        build_model();
        snap = tb_mem;
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        chk(busy == 1'b1, "R11", {tag, " busy after start"}, busy, 1);
        n = 0;
        while (!(done || error) && n < 5000) begin
            @(negedge clk);
            n++;
        end
        chk(n < 5000, "R11", {tag, " completion seen"}, n, 0);
        chk(error == m_err && done == !m_err, tag, "error flag", error, m_err);
        if (!m_err) begin
            chk(next_dst_x == m_nx, "R10", {tag, " next_dst_x"}, next_dst_x, m_nx);
            chk(next_dst_y == m_ny, "R10", {tag, " next_dst_y"}, next_dst_y, m_ny);
        end
        if (hold_start) begin
            start = 1'b1;            // start coincides with the done pulse
            @(negedge clk) start = 1'b0;
            for (int i = 0; i < 4; i++) begin
                chk(busy == 1'b0 && mem_rd == 1'b0, "R11", "start at done ignored", busy, 0);
                @(negedge clk);
            end
        end else begin
            @(negedge clk);
            chk(busy == 1'b0, "R11", {tag, " busy released"}, busy, 0);
        end
        chk(exp_addr.size() == 0, tag, "writes outstanding", exp_addr.size(), 0);
        bad = 0;
        for (int i = 0; i < MEM; i++) if (tb_mem[i] !== ref_mem[i]) bad++;
        chk(bad == 0, tag, "memory image mismatches", bad, 0);
        if (bad != 0) ref_mem = tb_mem;
        if (chk_move && !m_err && !m_empty) begin
            bad = 0;
            for (int y = 0; y < int'(cfg_h); y++)
                for (int k = 0; k < int'(cfg_w) * m_b; k++)
                    if (tb_mem[m_db + (int'(m_dt) + y) * m_dp + int'(m_dl) * m_b + k] !==
                        snap[m_sb + (int'(m_st) + y) * m_sp + int'(m_sl) * m_b + k]) bad++;
            chk(bad == 0, "R8", {tag, " overlap result equals original source"}, bad, 0);
        end
    endtask

    task automatic setup(input logic [3:0] fmt, input bit xf, input bit yf,
                         input int sx, input int sy, input int dx, input int dy,
                         input int w, input int h);
        cfg_fmt = fmt; cfg_xf = xf; cfg_yf = yf;
        cfg_sx = 16'(sx); cfg_sy = 16'(sy); cfg_dx = 16'(dx); cfg_dy = 16'(dy);
        cfg_w = 16'(w); cfg_h = 16'(h);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        for (int i = 0; i < MEM; i++) begin
            tb_mem[i]  = 8'(i * 7 + 3);
            ref_mem[i] = 8'(i * 7 + 3);
        end
        repeat (3) @(negedge clk);
        chk(!busy && !done && !error && !mem_rd && !mem_wr, "R11", "reset outputs idle",
            {busy, done, error, mem_rd, mem_wr}, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R1/R8: 8 bpp plain copy, own pitch and base (R6)
        cfg_own = 1'b1; cfg_sp = 64; cfg_dp = 32; cfg_sb = 0; cfg_db = 2048;
        cfg_shp = 0; cfg_shb = 0;
        setup(4'd2, 1, 1, 3, 2, 5, 1, 6, 3);
        run_op("R1", 1, 0);
        // R6: shared pitch/base with 16 bpp code 3
        cfg_own = 1'b0; cfg_shp = 48; cfg_shb = 1024; cfg_sp = 0; cfg_dp = 0;
        setup(4'd3, 1, 1, 0, 0, 8, 6, 4, 2);
        run_op("R6", 1, 0);
        // R6: zero shared pitch rejects even with nonzero own pitches (R5)
        cfg_sp = 64; cfg_dp = 64; cfg_shp = 0;
        run_op("R5", 0, 0);
        cfg_own = 1'b1; cfg_sp = 64; cfg_dp = 64; cfg_sb = 0; cfg_db = 0;
        // R1: 16 bpp code 4 and 32 bpp code 6
        setup(4'd4, 1, 1, 1, 10, 2, 40, 3, 2);
        run_op("R1", 1, 0);
        setup(4'd6, 1, 1, 0, 12, 4, 44, 4, 3);
        run_op("R1", 1, 0);
        // R2/R3: 24 bpp, right-to-left and bottom-up, coordinates are far edges
        setup(4'd5, 0, 0, 6, 5, 15, 50, 3, 2);
        run_op("R3", 1, 0);
        // R7: bottom-up rows sliding down onto themselves
        setup(4'd2, 1, 0, 0, 23, 0, 25, 6, 4);
        run_op("R7", 1, 0);
        // R7: top-down rows sliding up
        setup(4'd2, 1, 1, 4, 32, 4, 30, 5, 4);
        run_op("R7", 1, 0);
        // R8: horizontal overlap, destination to the right and to the left
        setup(4'd2, 1, 1, 10, 5, 12, 5, 8, 1);
        run_op("R8", 1, 0);
        setup(4'd2, 1, 1, 12, 6, 10, 6, 8, 1);
        run_op("R8", 1, 0);
        // R1: unsupported format code 7
        setup(4'd7, 1, 1, 0, 0, 1, 1, 2, 2);
        run_op("R1", 0, 0);
        // R5: zero destination pitch
        cfg_dp = 0;
        setup(4'd2, 1, 1, 0, 0, 1, 1, 2, 2);
        run_op("R5", 0, 0);
        cfg_dp = 64;
        // R4: destination coordinate above limit
        setup(4'd2, 1, 1, 0, 0, 16'h4000, 0, 2, 2);
        run_op("R4", 0, 0);
        // R2/R4: reversed X wraps below zero
        setup(4'd2, 0, 1, 9, 0, 1, 0, 4, 1);
        run_op("R2", 0, 0);
        // R9: end exactly at memory size accepted, one byte past rejected
        setup(4'd2, 1, 1, 0, 0, 60, 60, 4, 4);
        run_op("R9", 1, 0);
        setup(4'd2, 1, 1, 0, 0, 60, 60, 5, 4);
        run_op("R9", 0, 0);
        // R12: zero width completes without memory access
        setup(4'd2, 1, 1, 0, 0, 7, 9, 0, 3);
        run_op("R12", 0, 0);
        // R11: start held in the done cycle is ignored
        setup(4'd2, 1, 1, 0, 40, 20, 40, 3, 1);
        run_op("R11", 1, 1);
        // R13 covered by the write-stream monitor throughout
        chk(1'b1, "R13", "stream monitor active", 0, 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule